// File: doc/BRIEF.md
# Double-Buffered PWM Output Timer

This block drives one output pin with a pulse-width modulated waveform. The timer counts on the system clock, and the waveform is set by a period value and a pulse width value. Software writes both over a small register bus into shadow buffers. The working copies take these values only when a new period begins, so a change never cuts a period short.

Four control inputs set how the timer behaves. They choose the pulse polarity and switch on an alternating mode, in which every second period places its pulse at the end of the period instead of the start. They also start and stop the timer and allow the per-period interrupt. When the enable is dropped, the current period runs to its end before the timer stops. A running flag shows whether the timer is still active, and a configuration error flag shows when the width cannot fit inside the period.

Top module: `pwm_timer`

## Requirements
- R1: A running period lasts exactly PERIOD clock cycles. In a normal (non-mirrored) period the pin is active for the first WIDTH cycles and inactive for the remaining PERIOD-WIDTH cycles. The pin shows the level of each counter state one clock later.
- R2: With pulse_hi=1 the active level is 1 and the inactive level is 0. With pulse_hi=0 both levels are inverted. While the timer is idle, the pin sits at the inactive level.
- R3: A bus write with wr_addr=0 loads the period buffer, and a write with wr_addr=1 loads the width buffer. The working values change only when a period starts, so writes made during a period shape only the next one.
- R4: With toggle_en=1, the first period after start is normal and every second period after it is mirrored: inactive for PERIOD-WIDTH cycles, then active for WIDTH cycles.
- R5: When enable falls during a period, that period still completes. running stays 1 until the period ends and then drops to 0. The pin goes to its inactive level one clock after it shows the period's final state.
- R6: At each period end with irq_en=1, a sticky irq flag is set. A write to wr_addr=2 with data bit 0 set clears the flag. If a set and a clear happen in the same cycle, the set wins.
- R7: While running, cfg_err is 1 when WIDTH=0 or WIDTH>=PERIOD. In that state the pin holds its inactive level. cfg_err is 0 while idle.
- R8: When enable is high while the timer is idle, the next clock starts a period using the buffered values, and running rises at that clock.
- R9: After reset, pwm_out, running, irq and cfg_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 period, 1 width, 2 interrupt clear |
| wr_data | input | CW | Write data |
| enable | input | 1 | Start, or request a stop at the end of the period |
| pulse_hi | input | 1 | Active level of the pulse |
| toggle_en | input | 1 | Mirror the pulse in alternate periods |
| irq_en | input | 1 | Allow the period-end interrupt |
| pwm_out | output | 1 | Waveform pin |
| running | output | 1 | Timer active |
| irq | output | 1 | Sticky interrupt flag |
| cfg_err | output | 1 | Width does not fit the running period |

## Verification
The assertions check a set of rules on every cycle. running may rise only after enable and fall only after enable has gone low. The pin must stay inactive while the timer is idle or in a configuration error. irq may appear only when it is allowed during a running period, and it must persist until it is cleared. Several behaviours can only be shown by the bench's scenarios, which sweep many period and width pairs. These are the exact position of each pulse, the moment buffered writes take effect, the mirrored placement in alternate periods, and the end-of-period timing of a stop.

// File: rtl/pwm_tmr_pkg.sv
`timescale 1ns/1ps
package pwm_tmr_pkg;
   typedef enum logic [1:0] {
      ADDR_PERIOD = 2'd0,
      ADDR_WIDTH  = 2'd1,
      ADDR_STATUS = 2'd2
   } pwm_addr_e;
endpackage

// File: rtl/pwm_shadow.sv
`timescale 1ns/1ps
// Shadow buffers written from the register bus, plus the interrupt clear strobe.
module pwm_shadow
   import pwm_tmr_pkg::*;
#(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   output logic [CW-1:0] per_buf,
   output logic [CW-1:0] wid_buf,
   output logic          irq_clr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_buf <= '0;
         wid_buf <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_PERIOD) per_buf <= wr_data;
         if (wr_addr == ADDR_WIDTH)  wid_buf <= wr_data;
      end
   end

   assign irq_clr = wr_en && (wr_addr == ADDR_STATUS) && wr_data[0];
endmodule

// File: rtl/pwm_seq.sv
`timescale 1ns/1ps
// Period sequencer: counter, working copies, mirror phase, graceful stop.
module pwm_seq #(
   parameter int CW         = 32,
   parameter bit HAS_TOGGLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enable,
   input  logic          toggle_en,
   input  logic [CW-1:0] per_buf,
   input  logic [CW-1:0] wid_buf,
   output logic          run,
   output logic [CW-1:0] cnt,
   output logic          phase,
   output logic [CW-1:0] per_act,
   output logic [CW-1:0] wid_act,
   output logic          wrap
);
   logic [CW:0] cnt_inc;
   logic        phase_nxt;

   assign cnt_inc = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
   assign wrap    = run && (cnt_inc >= {1'b0, per_act});

   generate
      if (HAS_TOGGLE) begin : g_tog
         assign phase_nxt = toggle_en & ~phase;
      end else begin : g_notog
         assign phase_nxt = toggle_en & 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run     <= 1'b0;
         cnt     <= '0;
         phase   <= 1'b0;
         per_act <= '0;
         wid_act <= '0;
      end else if (!run) begin
         if (enable) begin
            run     <= 1'b1;
            cnt     <= '0;
            phase   <= 1'b0;
            per_act <= per_buf;
            wid_act <= wid_buf;
         end
      end else if (wrap) begin
         cnt <= '0;
         if (enable) begin
            per_act <= per_buf;
            wid_act <= wid_buf;
            phase   <= phase_nxt;
         end else begin
            run   <= 1'b0;
            phase <= 1'b0;
         end
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/pwm_wave.sv
`timescale 1ns/1ps
// Compare logic, configuration check, polarity and registered pin.
module pwm_wave #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] cnt,
   input  logic          phase,
   input  logic [CW-1:0] per_act,
   input  logic [CW-1:0] wid_act,
   input  logic          pulse_hi,
   output logic          pwm_out,
   output logic          cfg_err
);
   logic [CW-1:0] mirror_start;
   logic          in_pulse;
   logic          drive_act;

   assign cfg_err      = run && ((wid_act == '0) || (wid_act >= per_act));
   assign mirror_start = per_act - wid_act;
   assign in_pulse     = phase ? (cnt >= mirror_start) : (cnt < wid_act);
   assign drive_act    = run && !cfg_err && in_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_out <= 1'b0;
      else        pwm_out <= drive_act ? pulse_hi : ~pulse_hi;
   end
endmodule

// File: rtl/pwm_timer.sv
`timescale 1ns/1ps
module pwm_timer #(
   parameter int CW         = 32,
   parameter bit HAS_TOGGLE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [CW-1:0] wr_data,
   input  logic          enable,
   input  logic          pulse_hi,
   input  logic          toggle_en,
   input  logic          irq_en,
   output logic          pwm_out,
   output logic          running,
   output logic          irq,
   output logic          cfg_err
);
   localparam int MIN_CW = 4;
   localparam int MAX_CW = 64;

   initial begin
      if (CW < MIN_CW || CW > MAX_CW) $fatal(1, "pwm_timer: CW out of range");
   end

   logic [CW-1:0] per_buf, wid_buf, per_act, wid_act, cnt;
   logic          irq_clr, run, phase, wrap, irq_q;

   pwm_shadow #(.CW(CW)) u_shadow (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .per_buf(per_buf), .wid_buf(wid_buf),
      .irq_clr(irq_clr)
   );

   pwm_seq #(.CW(CW), .HAS_TOGGLE(HAS_TOGGLE)) u_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable), .toggle_en(toggle_en),
      .per_buf(per_buf), .wid_buf(wid_buf), .run(run), .cnt(cnt),
      .phase(phase), .per_act(per_act), .wid_act(wid_act), .wrap(wrap)
   );

   pwm_wave #(.CW(CW)) u_wave (
      .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt), .phase(phase),
      .per_act(per_act), .wid_act(wid_act), .pulse_hi(pulse_hi),
      .pwm_out(pwm_out), .cfg_err(cfg_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= (wrap & irq_en) | (irq_q & ~irq_clr);
   end

   assign irq     = irq_q;
   assign running = run;
endmodule

// File: rtl/pwm_timer_chk.sv
`timescale 1ns/1ps
module pwm_timer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic       wr_d0,
   input logic       enable,
   input logic       pulse_hi,
   input logic       irq_en,
   input logic       pwm_out,
   input logic       running,
   input logic       irq,
   input logic       cfg_err
);
   AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(running)) |-> $past(enable)); // R8
   AST_STOP_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $fell(running)) |-> !$past(enable)); // R5
   AST_IDLE_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !running && !$past(running) && $stable(pulse_hi))
      |-> (pwm_out == !pulse_hi)); // R2
   AST_ERR_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(cfg_err) && $stable(pulse_hi))
      |-> (pwm_out == !pulse_hi)); // R7
   AST_ERR_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> running); // R7
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $rose(irq)) |-> ($past(irq_en) && $past(running))); // R6
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(wr_en && wr_addr == 2'd2 && wr_d0)) |=> irq); // R6
endmodule

bind pwm_timer pwm_timer_chk chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_d0(wr_data[0]), .enable(enable), .pulse_hi(pulse_hi),
   .irq_en(irq_en), .pwm_out(pwm_out), .running(running), .irq(irq),
   .cfg_err(cfg_err)
);

// File: tb/pwm_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_tb_top;
   import pwm_tmr_pkg::*;
   localparam int CW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [CW-1:0] wr_data = '0;
   logic enable = 1'b0, pulse_hi = 1'b1, toggle_en = 1'b0, irq_en = 1'b0;
   logic pwm_out, running, irq, cfg_err;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwm_timer #(.CW(CW), .HAS_TOGGLE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .enable(enable), .pulse_hi(pulse_hi),
      .toggle_en(toggle_en), .irq_en(irq_en), .pwm_out(pwm_out),
      .running(running), .irq(irq), .cfg_err(cfg_err)
   );

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wr(logic [1:0] a, int d);
      wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Two periods: (p0,w0) then (p1,w1); second values written during the first period.
   task automatic run2(int p0, int w0, int p1, int w1, bit tog, bit pol, bit ien);
      int total;
      total = p0 + p1;
      pulse_hi = pol; toggle_en = tog; irq_en = ien;
      wr(ADDR_PERIOD, p0);
      wr(ADDR_WIDTH, w0);
      wr(ADDR_STATUS, 1);
      @(negedge clk);
      chk("R2 idle level", int'(pwm_out), int'(!pol));
      chk("R6 irq cleared", int'(irq), 0);
      enable = 1'b1;
      @(negedge clk);
      chk("R8 running after start", int'(running), 1);
      for (int s = 0; s <= total; s++) begin
         int q, idx, pp, ww, e_act, e_err;
         wr_en = 1'b0;
         if (s == 0) begin wr_en = 1'b1; wr_addr = ADDR_PERIOD; wr_data = CW'(p1); end
         if (s == 1) begin wr_en = 1'b1; wr_addr = ADDR_WIDTH;  wr_data = CW'(w1); end
         if (s == p0 - 1) begin wr_en = 1'b1; wr_addr = ADDR_STATUS; wr_data = CW'(1); end
         if (s == p0) enable = 1'b0;
         @(negedge clk);
         q   = (s < p0) ? 0 : 1;
         idx = q ? s - p0 : s;
         pp  = q ? p1 : p0;
         ww  = q ? w1 : w0;
         if (s == total) e_act = 0;
         else if (ww == 0 || ww >= pp) e_act = 0;
         else if (tog && q == 1) e_act = (idx >= pp - ww) ? 1 : 0; // R4 mirrored
         else e_act = (idx < ww) ? 1 : 0;                           // R1 normal
         chk(s == total ? "R5 inactive after stop" : "R1 R3 R4 pin level",
             int'(pwm_out), e_act ? int'(pol) : int'(!pol));
         chk("R5 running until period end", int'(running), (s + 1 < total) ? 1 : 0);
         if (s + 1 < p0) e_err = (w0 == 0 || w0 >= p0) ? 1 : 0;
         else if (s + 1 < total) e_err = (w1 == 0 || w1 >= p1) ? 1 : 0;
         else e_err = 0;
         chk("R7 cfg_err", int'(cfg_err), e_err);
         if (s == p0 - 2) chk("R6 irq before period end", int'(irq), 0);
         if (s == p0 - 1) chk("R6 irq set wins over clear", int'(irq), int'(ien));
         if (s == total - 1) chk("R6 irq at final period end", int'(irq), int'(ien));
      end
      wr_en = 1'b0;
      wr(ADDR_STATUS, 1);
      chk("R6 irq write-one-clear", int'(irq), 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset pwm_out", int'(pwm_out), 0);
      chk("R9 reset running", int'(running), 0);
      chk("R9 reset irq", int'(irq), 0);
      chk("R9 reset cfg_err", int'(cfg_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int p0 = 4; p0 <= 8; p0++)
         for (int w0 = 0; w0 <= p0; w0++)
            for (int tog = 0; tog < 2; tog++) begin
               int p1, w1;
               p1 = 2 + ((p0 + w0) % 6);
               w1 = (w0 * 3 + 1) % (p1 + 1);
               run2(p0, w0, p1, w1, tog[0], ((w0 + tog) % 2) == 1, ((p0 + w0) % 2) == 1);
            end
      run2(5, 9, 3, 7, 1'b0, 1'b1, 1'b1);   // R7 width above period
      run2(6, 2, 6, 4, 1'b1, 1'b0, 1'b1);   // R4 with low polarity
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule